// File: doc/BRIEF.md
# Edge-Pair Hit Word Builder

This block turns a stream of recorded wire transitions into packed hit words. Each input beat carries a channel number, a polarity flag and an arrival time. The arrival time is an 11-bit count measured from the first-level trigger, so it runs from 0 to 2047 ns. A beat can instead be an end-of-channel marker. The block keeps at most one open leading edge. When the trailing edge on the same channel arrives, the block emits a 32-bit word that holds the channel, the pulse width and the hit time.

Edges that cannot be paired still produce words, each marked with a fixed width value:
- A leading edge left open is emitted with a width of all ones. This happens at an end-of-channel marker, at a second leading edge, or at an edge on another channel.
- A trailing edge with nothing open is emitted with a width of zero.

Input and output both use valid/ready handshakes. The output is a single registered word, and a stalled output stalls the input.

Top module: `hitword_pairer`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and no leading edge is open.
- R2: Every output word has bits 31:29 at zero, the channel in bits 28:22, the width in bits 21:11 and the hit time in bits 10:0.
- R3: A trailing edge on the channel of the open leading edge emits a paired word. Its width is (trailing time − leading time) modulo 2048 and its hit time is the leading time. This word closes the open edge.
- R4: An end-of-channel marker (in_eoc=1, other fields ignored) closes an open leading edge by emitting a word with width 0x7FF and the leading time as hit time.
- R5: A trailing edge (in_trail=1) with no open leading edge emits a word with width 0 and the trailing time as hit time.
- R6: A leading edge (in_trail=0) on the channel of an open leading edge first emits the open one with width 0x7FF, then becomes the new open edge.
- R7: An edge on a channel other than that of the open leading edge first emits the open one with width 0x7FF. A trailing edge then follows as a width-0 word; a leading edge becomes the new open edge. Output order matches this sequence.
- R8: While out_valid is 1 and out_ready is 0, out_word holds its value and out_valid stays 1.
- R9: While out_valid is 1 and out_ready is 0, in_ready is 0.
- R10: An end-of-channel marker with nothing open, or a leading edge alone, produces no output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat accepted this cycle when in_valid is 1 |
| in_eoc | input | 1 | Beat is an end-of-channel marker |
| in_trail | input | 1 | 1 = trailing (high-to-low) edge, 0 = leading (low-to-high) edge |
| in_chan | input | 7 | Channel number |
| in_time | input | 11 | Edge time from trigger |
| out_valid | output | 1 | Hit word present |
| out_ready | input | 1 | Consumer takes the hit word |
| out_word | output | 32 | Packed hit word |

## Verification
The hardest situation to reach is a trailing edge on a new channel while another channel's leading edge is still open. Handling it takes two words and a refused input beat, and it is harder still when the output is stalled at the same moment. The random stimulus draws from only four channels and mixes polarities, which opens and breaks pairs across channels often. A consumer whose out_ready is random keeps the backpressure shifting under these two-word sequences. Directed cases cover each orphan kind, the duplicate leading edge, and equal times at 2047.

// File: rtl/hwb_pkg.sv
package hwb_pkg;
  // what the decision logic does with the current beat
  typedef enum logic [1:0] {
    ACT_NONE       = 2'd0,
    ACT_PAIR       = 2'd1,
    ACT_ORPH_LEAD  = 2'd2,
    ACT_ORPH_TRAIL = 2'd3
  } hwb_act_e;
endpackage

// File: rtl/hwb_decide.sv
module hwb_decide
  import hwb_pkg::*;
#(
  parameter int CHAN_W = 7,
  parameter int TIME_W = 11
) (
  input  logic              in_valid,
  input  logic              in_eoc,
  input  logic              in_trail,
  input  logic [CHAN_W-1:0] in_chan,
  input  logic [TIME_W-1:0] in_time,
  input  logic              pend_vld,
  input  logic [CHAN_W-1:0] pend_chan,
  input  logic [TIME_W-1:0] pend_time,
  input  logic              slot_free,
  output logic              in_ready,
  output logic              emit,
  output logic [CHAN_W-1:0] emit_chan,
  output logic [TIME_W-1:0] emit_width,
  output logic [TIME_W-1:0] emit_time,
  output logic              pend_load,
  output logic              pend_clear
);
  localparam logic [TIME_W-1:0] WIDTH_OPEN = '1;
  localparam logic [TIME_W-1:0] WIDTH_NONE = '0;

  hwb_act_e act;
  logic     conflict;
  logic     hold_beat;

  always_comb begin
    conflict  = pend_vld && (in_eoc || !in_trail || (in_chan != pend_chan));
    hold_beat = 1'b0;
    act       = ACT_NONE;
    pend_load  = 1'b0;
    pend_clear = 1'b0;
    if (in_valid) begin
      if (conflict) begin
        act = ACT_ORPH_LEAD;
        if (in_trail && !in_eoc) begin
          // trailing edge elsewhere: flush first, take the beat next cycle
          hold_beat  = 1'b1;
          pend_clear = slot_free;
        end else if (in_eoc) begin
          pend_clear = slot_free;
        end else begin
          pend_load = slot_free;
        end
      end else if (pend_vld) begin
        act        = ACT_PAIR;
        pend_clear = slot_free;
      end else if (!in_eoc) begin
        if (in_trail) act = ACT_ORPH_TRAIL;
        else          pend_load = slot_free;
      end
    end
  end

  always_comb begin
    emit       = slot_free && (act != ACT_NONE);
    in_ready   = slot_free && !hold_beat;
    emit_chan  = pend_chan;
    emit_time  = pend_time;
    emit_width = WIDTH_OPEN;
    case (act)
      ACT_PAIR:       emit_width = in_time - pend_time;
      ACT_ORPH_TRAIL: begin
        emit_chan  = in_chan;
        emit_time  = in_time;
        emit_width = WIDTH_NONE;
      end
      default:        emit_width = WIDTH_OPEN;
    endcase
  end
endmodule

// File: rtl/hwb_pend.sv
module hwb_pend #(
  parameter int CHAN_W = 7,
  parameter int TIME_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend_load,
  input  logic              pend_clear,
  input  logic [CHAN_W-1:0] in_chan,
  input  logic [TIME_W-1:0] in_time,
  output logic              pend_vld,
  output logic [CHAN_W-1:0] pend_chan,
  output logic [TIME_W-1:0] pend_time
);
  logic vld_nxt;

  always_comb begin
    vld_nxt = pend_vld;
    if (pend_clear) vld_nxt = 1'b0;
    if (pend_load)  vld_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_vld <= 1'b0;
    else        pend_vld <= vld_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_chan <= '0;
      pend_time <= '0;
    end else if (pend_load) begin
      pend_chan <= in_chan;
      pend_time <= in_time;
    end
  end

  // R1: a load and a clear never coincide
  assert_load_xor_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_load && pend_clear));
endmodule

// File: rtl/hwb_outreg.sv
module hwb_outreg #(
  parameter int CHAN_W = 7,
  parameter int TIME_W = 11,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_free,
  input  logic              emit,
  input  logic [CHAN_W-1:0] emit_chan,
  input  logic [TIME_W-1:0] emit_width,
  input  logic [TIME_W-1:0] emit_time,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word
);
  localparam int PAD_W = WORD_W - CHAN_W - 2*TIME_W;

  logic [WORD_W-1:0] word_nxt;

  always_comb begin
    word_nxt = {{PAD_W{1'b0}}, emit_chan, emit_width, emit_time};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         out_valid <= 1'b0;
    else if (slot_free) out_valid <= emit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    out_word <= '0;
    else if (emit) out_word <= word_nxt;
  end

  assert_hold_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));
endmodule

// File: rtl/hitword_pairer.sv
module hitword_pairer #(
  parameter int CHAN_W = 7,
  parameter int TIME_W = 11,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_eoc,
  input  logic              in_trail,
  input  logic [CHAN_W-1:0] in_chan,
  input  logic [TIME_W-1:0] in_time,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word
);
  localparam int WID_LO = TIME_W;
  localparam int WID_HI = 2*TIME_W - 1;
  localparam int TOP_LO = CHAN_W + 2*TIME_W;

  logic              slot_free;
  logic              pend_vld, pend_load, pend_clear, emit;
  logic [CHAN_W-1:0] pend_chan, emit_chan;
  logic [TIME_W-1:0] pend_time, emit_width, emit_time;

  always_comb slot_free = !out_valid || out_ready;

  hwb_decide #(.CHAN_W(CHAN_W), .TIME_W(TIME_W)) u_decide (
    .in_valid(in_valid), .in_eoc(in_eoc), .in_trail(in_trail),
    .in_chan(in_chan), .in_time(in_time),
    .pend_vld(pend_vld), .pend_chan(pend_chan), .pend_time(pend_time),
    .slot_free(slot_free), .in_ready(in_ready), .emit(emit),
    .emit_chan(emit_chan), .emit_width(emit_width), .emit_time(emit_time),
    .pend_load(pend_load), .pend_clear(pend_clear)
  );

  hwb_pend #(.CHAN_W(CHAN_W), .TIME_W(TIME_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .pend_load(pend_load), .pend_clear(pend_clear),
    .in_chan(in_chan), .in_time(in_time),
    .pend_vld(pend_vld), .pend_chan(pend_chan), .pend_time(pend_time)
  );

  hwb_outreg #(.CHAN_W(CHAN_W), .TIME_W(TIME_W), .WORD_W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_n), .slot_free(slot_free), .emit(emit),
    .emit_chan(emit_chan), .emit_width(emit_width), .emit_time(emit_time),
    .out_ready(out_ready), .out_valid(out_valid), .out_word(out_word)
  );

  assert_pad_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_word[WORD_W-1:TOP_LO] == '0));

  assert_stall_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_lone_marker_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_eoc && !pend_vld) |=> !out_valid);

  assert_orphan_trail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_trail && !in_eoc && !pend_vld)
      |=> (out_valid && out_word[WID_HI:WID_LO] == '0));
endmodule

// File: tb/sim_hitword_pairer.sv
module sim_hitword_pairer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_eoc = 1'b0, in_trail = 1'b0, out_ready = 1'b0;
  logic [6:0]  in_chan = '0;
  logic [10:0] in_time = '0;
  logic        in_ready, out_valid;
  logic [31:0] out_word;

  int checks = 0, bad = 0, cycles = 0;
  bit finished = 0;
  bit rdy_random = 1;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  // bench model state
  bit          m_open = 0;
  logic [6:0]  m_chan = '0;
  logic [10:0] m_time = '0;

  hitword_pairer u0 (.*);

  always #4 clk = ~clk;

  function automatic logic [31:0] mk(input logic [6:0] c, input logic [10:0] w,
                                     input logic [10:0] t);
    return {3'b000, c, w, t};
  endfunction

  function automatic void push(input logic [31:0] w, input string tag);
    exp_q.push_back(w);
    tag_q.push_back(tag);
  endfunction

  function automatic void model(input bit eoc, input bit tr, input logic [6:0] c,
                                input logic [10:0] t);
    if (m_open && (eoc || !tr || c != m_chan)) begin
      push(mk(m_chan, 11'h7FF, m_time), eoc ? "R4" : (c != m_chan ? "R7" : "R6"));
      m_open = 0;
    end
    if (eoc) return;
    if (tr) begin
      if (m_open) begin
        push(mk(c, t - m_time, m_time), "R3");
        m_open = 0;
      end else push(mk(c, 11'd0, t), "R5");
    end else begin
      m_open = 1; m_chan = c; m_time = t;
    end
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input bit eoc, input bit tr, input logic [6:0] c,
                      input logic [10:0] t);
    model(eoc, tr, c, t);
    @(negedge clk);
    in_valid = 1; in_eoc = eoc; in_trail = tr; in_chan = c; in_time = t;
    forever begin
      #2;
      if (out_valid && !out_ready)
        check(!in_ready, "R9", {31'd0, in_ready}, 32'd0);
      if (in_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    #1 in_valid = 0;
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
  endtask

  // output monitor: transfer happens at the posedge after this sample
  logic [31:0] last_word;
  bit          was_stalled = 0;
  always begin
    @(negedge clk);
    out_ready = rdy_random ? ($urandom_range(0, 3) != 0) : 1'b1;
    #1;
    if (rst_n) begin
      if (was_stalled)
        check(out_valid && out_word == last_word, "R8", out_word, last_word);
      was_stalled = out_valid && !out_ready;
      last_word   = out_word;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R10", out_word, 32'd0);
        end else begin
          logic [31:0] e;
          string       tg;
          e  = exp_q.pop_front();
          tg = tag_q.pop_front();
          check(out_word == e, tg, out_word, e);
          check(out_word[31:29] == 3'b000, "R2", out_word, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1997));
    repeat (3) @(negedge clk);
    rdy_random = 0;
    rst_n = 1;
    @(negedge clk);
    #2;
    // R1 reset state
    check(!out_valid, "R1", {31'd0, out_valid}, 32'd0);
    check(in_ready, "R1", {31'd0, in_ready}, 32'd1);

    // R10: marker alone and leading alone give nothing
    send(1, 0, 7'd9, 11'd0);
    repeat (3) @(negedge clk);
    #2 check(!out_valid, "R10", {31'd0, out_valid}, 32'd0);
    send(0, 0, 7'd3, 11'd100);
    repeat (3) @(negedge clk);
    #2 check(!out_valid, "R10", {31'd0, out_valid}, 32'd0);
    send(0, 1, 7'd3, 11'd350);            // R3 width 250
    drain();
    send(0, 0, 7'd5, 11'd10); send(1, 0, 7'd0, 11'd0);          // R4
    send(0, 1, 7'd6, 11'd77);                                    // R5
    send(0, 0, 7'd1, 11'd5); send(0, 0, 7'd1, 11'd20);
    send(0, 1, 7'd1, 11'd50);                                    // R6
    send(0, 0, 7'd2, 11'd40); send(0, 1, 7'd9, 11'd60);          // R7
    send(0, 0, 7'd127, 11'd2047); send(0, 1, 7'd127, 11'd2047);  // R3 boundary
    send(0, 0, 7'd4, 11'd0); send(0, 1, 7'd4, 11'd2047);         // R3 max width
    drain();

    // random phase with backpressure
    rdy_random = 1;
    for (int i = 0; i < 600; i++) begin
      int r = $urandom_range(0, 9);
      send(r == 0, r > 4, 7'($urandom_range(0, 3)), 11'($urandom_range(0, 2047)));
    end
    send(1, 0, 7'd0, 11'd0);
    drain();
    rdy_random = 0;
    drain();
    check(exp_q.size() == 0, "R7", exp_q.size(), 32'd0);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule